// File: doc/BRIEF.md
# Full-Duplex SPI Host Engine with Automatic Chip Select

This block is a full-duplex SPI host engine that sits between a transmit queue and a receive queue. Each word taken from the transmit side is shifted out on `mosi`, most significant bit first. At the same time the same number of bits are shifted in from `miso` and handed to the receive side as one word. The frame length can be set from 2 to 32 bits. Both clock phases are supported. Clock polarity is applied as an inversion on the `sck` pin, so the internal sequencing is identical for both polarities.

The engine drives chip select without software help. `cs_n` goes low as soon as a frame can start. It stays low for as long as another word is waiting at the end of each frame, so back-to-back frames stream under a single assertion. It rises only when the transmit side is empty at a frame boundary. A clock-enable divider sets the bit rate. Every `sck` period spans four enables, two low and two high. Fixed porches of two enables separate chip-select edges from clock edges. After a release, `cs_n` stays high for at least two enables before it can go low again.

Top module: `spi_acs_host`

## Requirements
- R1: While `rst_n` is low and after it is released with no data, `sck` and `mosi` are 0, `cs_n` is 1, and `tx_pop` and `rx_push` are 0.
- R2: `tx_data` is right-justified. Bit L-1 of an L-bit frame goes out on `mosi` first and bit 0 goes out last.
- R3: For every frame sent, exactly one `rx_push` occurs while `cs_n` is low. Its `rx_data` holds the L bits sampled from `miso`, right-justified, with the first-sampled bit at position L-1 and the upper bits zero.
- R4: The frame length is `cfg_len` limited to the range 2 to 32. A value below 2 gives 2 bits and a value above 32 gives 32 bits. Each frame produces exactly L leading `sck` edges.
- R5: Frames that are waiting at the end of a frame follow immediately under the same chip-select assertion. `cs_n` falls once per burst, and `tx_pop` is only raised while `tx_valid` is high.
- R6: After `cs_n` rises, it stays high for exactly two clock enables before the next frame starts when data is already waiting.
- R7: With `cfg_cpha`=0, the first leading `sck` edge comes two enables after `cs_n` falls, `miso` is sampled on leading edges, and `mosi` changes on trailing edges. `sck` then idles for two enables after its last edge before `cs_n` rises.
- R8: With `cfg_cpha`=1, `cs_n` is low with `sck` idle for two enables before the first leading edge. `mosi` changes on leading edges, `miso` is sampled on trailing edges, and `cs_n` rises two enables after the last edge.
- R9: While `cs_n` is high, `sck` rests at the level of `cfg_cpol`. With `cfg_cpol`=1 the whole `sck` waveform is inverted.
- R10: One clock enable occurs every `cfg_div`+1 clocks. Inside a burst, consecutive `sck` edges are exactly two enables apart.
- R11: No frame starts while `rx_room` is low. `cs_n` stays high and no word is popped.
- R12: The configuration inputs are taken only while the engine is idle with `cs_n` high. Changes made during a burst do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 6 | Requested frame length in bits |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | Clock polarity (idle level of sck) |
| cfg_div | input | 8 | Clock-enable divider; enable every cfg_div+1 clocks |
| tx_valid | input | 1 | Transmit side holds at least one word |
| tx_data | input | 32 | Head word of the transmit side, right-justified |
| tx_pop | output | 1 | Takes the head word this clock |
| rx_room | input | 1 | Receive side can accept a word |
| rx_push | output | 1 | rx_data is valid and is written this clock |
| rx_data | output | 32 | Received frame, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The hardest situation to reach from the ports is a configuration change that arrives in the middle of a burst. Every word is already queued and the frame boundaries are decided internally, so a wrong length or phase would only show up as a miscounted edge or a misaligned word several frames later. The bench waits for `cs_n` to fall and then rewrites length, phase and divider. It then confirms that the edge count, the edge spacing and every received word still follow the old settings. A second hard case is the exact two-enable release gap. The bench reaches it by queueing a new word in the same instant that `cs_n` rises, which forces the shortest legal gap.

// File: rtl/spi_acs_pkg.sv
package spi_acs_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_LEAD_IN,
        ENG_SHIFT,
        ENG_TAIL,
        ENG_REST
    } eng_state_e;

    typedef logic [1:0] quarter_t;

endpackage

// File: rtl/spi_ce_gen.sv
module spi_ce_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             ce
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ce    = (cnt_q >= div);
        cnt_d = ce ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word_in,
    input  logic [LEN_W-1:0]  len,
    input  logic              advance,
    input  logic              capture,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] word_out
);

    localparam logic [LEN_W:0] FULL = (LEN_W + 1)'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } shreg_t;

    shreg_t sh_d, sh_q;
    logic [LEN_W:0] shamt;

    always_comb begin
        sh_d  = sh_q;
        shamt = FULL - {1'b0, len};
        if (load) begin
            // left-justify so the frame's top bit sits at the serial output
            sh_d.tx = word_in << shamt;
            sh_d.rx = '0;
        end else begin
            if (advance) sh_d.tx = {sh_q.tx[DATA_W-2:0], 1'b0};
            if (capture) sh_d.rx = {sh_q.rx[DATA_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign mosi     = sh_q.tx[DATA_W-1];
    assign word_out = sh_q.rx;

endmodule

// File: rtl/spi_acs_host.sv
module spi_acs_host
    import spi_acs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_cpha,
    input  logic              cfg_cpol,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_room,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] div;
    } cfg_t;

    typedef struct packed {
        eng_state_e       st;
        quarter_t         ph;
        logic [LEN_W-1:0] left;
        logic             sck;
        logic             csn;
        cfg_t             cfg;
    } eng_t;

    function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(2))      return LEN_W'(2);
        if (raw > LEN_W'(DATA_W)) return LEN_W'(DATA_W);
        return raw;
    endfunction

    eng_t r_d, r_q;
    logic ce, can_go, load, advance, capture;
    logic sck_core;
    logic [LEN_W-1:0] len_live;

    spi_ce_gen #(.DIV_W(DIV_W)) i_ce_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (r_q.cfg.div),
        .ce   (ce)
    );

    spi_frame_shifter #(.DATA_W(DATA_W)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .word_in (tx_data),
        .len     (r_q.cfg.len),
        .advance (advance),
        .capture (capture),
        .miso    (miso),
        .mosi    (mosi),
        .word_out(rx_data)
    );

    always_comb begin
        r_d     = r_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        load    = 1'b0;
        advance = 1'b0;
        capture = 1'b0;
        can_go  = tx_valid && rx_room;

        case (r_q.st)
            ENG_IDLE: begin
                if (ce && can_go) begin
                    tx_pop   = 1'b1;
                    load     = 1'b1;
                    r_d.csn  = 1'b0;
                    r_d.left = r_q.cfg.len - LEN_W'(1);
                    r_d.ph   = 2'd0;
                    r_d.sck  = 1'b0;
                    r_d.st   = r_q.cfg.cpha ? ENG_LEAD_IN : ENG_SHIFT;
                end else begin
                    // settings follow the inputs only while deselected and idle
                    r_d.cfg.cpha = cfg_cpha;
                    r_d.cfg.cpol = cfg_cpol;
                    r_d.cfg.len  = fit_len(cfg_len);
                    r_d.cfg.div  = cfg_div;
                end
            end

            ENG_LEAD_IN: begin
                if (ce) begin
                    if (r_q.ph == 2'd0) begin
                        r_d.ph = 2'd1;
                    end else begin
                        r_d.ph  = 2'd0;
                        r_d.sck = 1'b1;
                        r_d.st  = ENG_SHIFT;
                    end
                end
            end

            ENG_SHIFT: begin
                if (ce) begin
                    case (r_q.ph)
                        2'd0: r_d.ph = 2'd1;
                        2'd1: begin
                            r_d.ph  = 2'd2;
                            r_d.sck = ~r_q.sck;
                            capture = 1'b1;
                        end
                        2'd2: r_d.ph = 2'd3;
                        default: begin
                            r_d.ph = 2'd0;
                            if (r_q.left != '0) begin
                                r_d.left = r_q.left - LEN_W'(1);
                                r_d.sck  = ~r_q.sck;
                                advance  = 1'b1;
                            end else begin
                                rx_push = 1'b1;
                                if (can_go) begin
                                    tx_pop   = 1'b1;
                                    load     = 1'b1;
                                    r_d.left = r_q.cfg.len - LEN_W'(1);
                                    r_d.sck  = ~r_q.sck;
                                end else if (r_q.cfg.cpha) begin
                                    r_d.csn = 1'b1;
                                    r_d.st  = ENG_REST;
                                end else begin
                                    r_d.sck = 1'b0;
                                    r_d.st  = ENG_TAIL;
                                end
                            end
                        end
                    endcase
                end
            end

            ENG_TAIL: begin
                if (ce) begin
                    if (r_q.ph == 2'd0) begin
                        r_d.ph = 2'd1;
                    end else begin
                        r_d.ph  = 2'd0;
                        r_d.csn = 1'b1;
                        r_d.st  = ENG_REST;
                    end
                end
            end

            default: begin
                if (ce) r_d.st = ENG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ENG_IDLE;
            r_q.csn <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck_core = r_q.sck;
    assign len_live = r_q.cfg.len;
    assign sck      = r_q.sck ^ r_q.cfg.cpol;
    assign cs_n     = r_q.csn;

endmodule

// File: rtl/spi_acs_host_chk.sv
module spi_acs_host_chk #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             tx_pop,
    input logic             tx_valid,
    input logic             rx_room,
    input logic             rx_push,
    input logic             sck_core,
    input logic [LEN_W-1:0] len_live
);

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid); // R5

    AST_START_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(rx_room)); // R11

    AST_PUSH_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !cs_n); // R3

    AST_SCK_REST_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck_core); // R9

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(len_live)); // R12

    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (len_live >= LEN_W'(2) && len_live <= LEN_W'(DATA_W))); // R4

    AST_GAP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R6

endmodule

bind spi_acs_host spi_acs_host_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .tx_pop  (tx_pop),
    .tx_valid(tx_valid),
    .rx_room (rx_room),
    .rx_push (rx_push),
    .sck_core(sck_core),
    .len_live(len_live)
);

// File: tb/test_spi_acs_host.sv
`timescale 1ns/1ps
module test_spi_acs_host;

    localparam int CLK_NS = 4;
    localparam int NVEC   = 8;
    // {cpha, cpol, len[5:0], div[7:0], frames[2:0], seed[31:0]}
    localparam logic [50:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 6'd8,  8'd3, 3'd3, 32'h5A17_C3E9},
        {1'b1, 1'b0, 6'd8,  8'd1, 3'd2, 32'h0F1E_2D3C},
        {1'b0, 1'b1, 6'd16, 8'd0, 3'd2, 32'hDEAD_B00F},
        {1'b1, 1'b1, 6'd32, 8'd2, 3'd2, 32'h8001_7FFE},
        {1'b0, 1'b0, 6'd1,  8'd1, 3'd1, 32'h0000_0003},
        {1'b1, 1'b0, 6'd5,  8'd0, 3'd4, 32'h1234_5678},
        {1'b0, 1'b1, 6'd40, 8'd0, 3'd1, 32'hC0DE_F00D},
        {1'b1, 1'b1, 6'd2,  8'd4, 3'd3, 32'hA5A5_5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_len = 6'd8;
    logic        cfg_cpha = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_pop;
    logic        rx_room = 1'b1;
    logic        rx_push;
    logic [31:0] rx_data;
    logic        sck, mosi, miso, cs_n;

    logic [31:0] txq [256];
    logic [31:0] mpat [256];
    logic [31:0] scap [256];
    logic [31:0] rxcap [256];
    logic [7:0]  wr = 8'd0;
    logic [7:0]  rd, rxn;
    logic [7:0]  sl_idx = 8'd0;
    logic [31:0] sl_in = '0;
    int          sl_bit = 0;
    logic        miso_r = 1'b0;

    logic tb_cpha = 1'b0, tb_pol = 1'b0;
    int   tb_len = 8;
    int   ce2 = 2;
    int   tests = 0, fails = 0, cyc = 0;
    int   cs_falls = 0, lead_cnt = 0, bad_w = 0;
    time  t_csfall = 0, t_csrise = 0, t_prev = 0, t_firstlead = 0, t_lastedge = 0;
    logic last_cs = 1'b1, last_sck = 1'b0;
    logic sck_l;

    assign tx_valid = (wr != rd);
    assign tx_data  = txq[rd];
    assign miso     = miso_r;
    assign sck_l    = sck ^ tb_pol;

    spi_acs_host i_spi_acs_host (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_cpha(cfg_cpha),
        .cfg_cpol(cfg_cpol), .cfg_div(cfg_div), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_room(rx_room),
        .rx_push(rx_push), .rx_data(rx_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    // transmit queue head and receive capture
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd  <= 8'd0;
            rxn <= 8'd0;
        end else begin
            if (tx_pop) rd <= rd + 8'd1;
            if (rx_push) begin
                rxcap[rxn] <= rx_data;
                rxn        <= rxn + 8'd1;
            end
        end
    end

    // serial device model and edge timing monitor
    always @(sck_l or cs_n) begin
        if (rst_n === 1'b1) begin
            if (cs_n !== last_cs) begin
                if (cs_n == 1'b0) begin
                    t_csfall = $time;
                    sl_bit   = 0;
                    sl_in    = '0;
                    cs_falls = cs_falls + 1;
                    if (!tb_cpha) miso_r = mpat[sl_idx][tb_len-1];
                end else begin
                    t_csrise = $time;
                end
            end else if (sck_l !== last_sck && cs_n == 1'b0) begin
                if (t_prev > t_csfall && ($time - t_prev) != time'(ce2 * CLK_NS))
                    bad_w = bad_w + 1;
                t_prev     = $time;
                t_lastedge = $time;
                if (sck_l) begin
                    lead_cnt = lead_cnt + 1;
                    if (t_firstlead < t_csfall) t_firstlead = $time;
                end
                if (sck_l == !tb_cpha) begin
                    sl_in  = {sl_in[30:0], mosi};
                    sl_bit = sl_bit + 1;
                    if (sl_bit == tb_len) begin
                        scap[sl_idx] = sl_in;
                        sl_idx       = sl_idx + 8'd1;
                        sl_bit       = 0;
                        sl_in        = '0;
                    end
                end else begin
                    miso_r = mpat[sl_idx][tb_len-1-sl_bit];
                end
            end
        end
        last_cs  = cs_n;
        last_sck = sck_l;
    end

    function automatic logic [31:0] lmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic int fit(input int n);
        return (n < 2) ? 2 : ((n > 32) ? 32 : n);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_frame(input logic [31:0] w);
        txq[wr]  = w;
        mpat[wr] = ~w ^ 32'hC3A5_0F96;
        wr       = wr + 8'd1;
    endtask

    task automatic apply_cfg(input logic ph, input logic pol, input int len, input int dv);
        @(negedge clk);
        cfg_cpha = ph;
        cfg_cpol = pol;
        cfg_len  = 6'(len);
        cfg_div  = 8'(dv);
        tb_cpha  = ph;
        tb_pol   = pol;
        tb_len   = fit(len);
        ce2      = 2 * (dv + 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_done(input int dv);
        int guard = 0;
        while (!(cs_n === 1'b1 && rd == wr) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (8 * (dv + 1) + 6) @(negedge clk);
    endtask

    task automatic check_frames(input string req2, input string req3, input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            check(req2, scap[8'(b + 8'(i))], txq[8'(b + 8'(i))] & lmask(tb_len));
            check(req3, rxcap[8'(b + 8'(i))], mpat[8'(b + 8'(i))] & lmask(tb_len));
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            txq[i] = '0; mpat[i] = '0; scap[i] = '0; rxcap[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: values held in reset
        check("R1 sck in reset", {31'b0, sck}, 32'd0);
        check("R1 mosi in reset", {31'b0, mosi}, 32'd0);
        check("R1 cs_n in reset", {31'b0, cs_n}, 32'd1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", {28'b0, sck, mosi, tx_pop, rx_push}, 32'd0);
        check("R1 cs_n after reset", {31'b0, cs_n}, 32'd1);

        // table of bursts
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] b;
            int f0, l0, w0, nfr, dv;
            logic ph;
            ph  = VEC[v][50];
            dv  = int'(VEC[v][42:35]);
            nfr = int'(VEC[v][34:32]);
            apply_cfg(ph, VEC[v][49], int'(VEC[v][48:43]), dv);
            b = wr; f0 = cs_falls; l0 = lead_cnt; w0 = bad_w;
            for (int i = 0; i < nfr; i++)
                push_frame(VEC[v][31:0] ^ (32'(i + 1) * 32'h9E37_79B9));
            wait_done(dv);
            check_frames("R2 mosi order", "R3 rx word", b, nfr);
            check("R3 push count", {24'b0, rxn}, {24'b0, wr});
            check("R4 leading edges", 32'(lead_cnt - l0), 32'(nfr * tb_len));
            check("R5 one select per burst", 32'(cs_falls - f0), 32'd1);
            check("R10 edge spacing", 32'(bad_w - w0), 32'd0);
            check(ph ? "R8 front porch" : "R7 first edge delay",
                  32'((t_firstlead - t_csfall) / CLK_NS), 32'(ce2));
            check(ph ? "R8 release delay" : "R7 back porch",
                  32'((t_csrise - t_lastedge) / CLK_NS), 32'(ce2));
            check("R9 idle level", {31'b0, sck}, {31'b0, VEC[v][49]});
        end

        // R9: idle level follows polarity while deselected
        apply_cfg(1'b0, 1'b1, 8, 0);
        check("R9 idle high", {31'b0, sck}, 32'd1);
        apply_cfg(1'b0, 1'b0, 8, 0);
        check("R9 idle low", {31'b0, sck}, 32'd0);

        // R11: no start without receive room
        begin
            logic [7:0] b;
            apply_cfg(1'b0, 1'b0, 8, 0);
            rx_room = 1'b0;
            b = wr;
            push_frame(32'h0000_00C6);
            repeat (100) @(negedge clk);
            check("R11 stays deselected", {31'b0, cs_n}, 32'd1);
            check("R11 word not taken", {24'b0, 8'(wr - rd)}, 32'd1);
            rx_room = 1'b1;
            wait_done(0);
            check_frames("R11 data after room", "R11 rx after room", b, 1);
        end

        // R6: shortest release gap with data waiting
        begin
            logic [7:0] b;
            time t_up;
            apply_cfg(1'b0, 1'b0, 8, 1);
            b = wr;
            push_frame(32'h0000_003A);
            push_frame(32'h0000_00B1);
            @(posedge cs_n);
            t_up = $time;
            push_frame(32'h0000_0047);
            @(negedge cs_n);
            check("R6 gap length", 32'(($time - t_up) / CLK_NS), 32'(ce2));
            wait_done(1);
            check_frames("R6 data", "R6 rx", b, 3);
        end

        // R12: settings changed during a burst are ignored
        begin
            logic [7:0] b;
            int l0, w0;
            apply_cfg(1'b1, 1'b0, 8, 1);
            b = wr; l0 = lead_cnt; w0 = bad_w;
            push_frame(32'h0000_0093);
            push_frame(32'h0000_006E);
            push_frame(32'h0000_0015);
            @(negedge cs_n);
            @(negedge clk);
            cfg_len  = 6'd16;
            cfg_cpha = 1'b0;
            cfg_div  = 8'd0;
            wait_done(1);
            check("R12 edge count", 32'(lead_cnt - l0), 32'd24);
            check("R12 edge spacing", 32'(bad_w - w0), 32'd0);
            check_frames("R12 mosi", "R12 rx", b, 3);
            apply_cfg(1'b0, 1'b0, 8, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule